// File: doc/BRIEF.md
# Time-Triggered Slot and Minislot Scheduler

This block keeps track of where a node stands inside one communication cycle of a time-triggered bus that has two phases. The block advances only on a macrotick enable. Each cycle starts with a static phase of equal-length TDMA slots, numbered from frame ID 1. A dynamic phase follows, in which every frame ID gets a minislot. That minislot passes as a short idle gap, or it stretches to carry a frame. A symbol window and a network idle period close the cycle, and then the cycle counter advances.

The host supplies the segment lengths, a bitmap of frames waiting to be sent (bit n belongs to frame ID n), one frame length that applies to every dynamic frame, and a bus-busy indication that reports traffic from other nodes. The block reports the current frame ID, the segment and the cycle number. It also pulses a transmit grant when a pending frame may start. A grant can only come at the first macrotick of a slot, so arbitration in the dynamic phase always favours the lowest ID and never involves contention on the wire. All configuration lengths are at least 1.

Top module: `tt_slot_sched`

## Requirements
- R1: While and after reset, with no macrotick since, the outputs read: segment static (code 0), frame ID 1, cycle 0, grant low.
- R2: Static frame IDs run from 1 up to the configured slot count in ascending order. Each slot lasts exactly the configured static slot length in macroticks, and this holds whether or not anything is sent in it.
- R3: If the bitmap bit of a static frame ID is set, the grant is high for the single clock that follows the slot's first macrotick. It is low at all other times.
- R4: The first dynamic frame ID is one above the last static ID. A dynamic slot with no transmission and no bus activity lasts one minislot, and then the ID increments.
- R5: When bus_busy is high on the last macrotick of a minislot that this node is not sending in, the slot keeps its ID and another full minislot begins.
- R6: A pending dynamic frame is granted at its slot's first macrotick, and that slot then lasts exactly the frame length in macroticks.
- R7: A dynamic frame is granted only if its length is no more than the macroticks left in the dynamic segment, counting the current one. Otherwise its slot passes as an idle minislot and the frame gets no grant in that cycle.
- R8: The dynamic segment lasts exactly its configured macrotick count, whatever its slots are doing. Next comes the symbol window (code 2, frame ID 0), then network idle (code 3, frame ID 0), each for its configured length. The dynamic code is 1.
- R9: The 6-bit cycle counter increments when network idle ends and the next static segment begins, and it wraps from 63 to 0.
- R10: No output changes in a clock without mt_en. A grant only follows a clock in which mt_en was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mt_en | input | 1 | Macrotick enable, one clock per macrotick |
| cfg_static_slots | input | ID_W | Number of static slots (1 to 1023) |
| cfg_static_len | input | LEN_W | Static slot length in macroticks |
| cfg_minislot_len | input | LEN_W | Minislot length in macroticks |
| cfg_dyn_len | input | SEG_W | Dynamic segment length in macroticks |
| cfg_sym_len | input | SEG_W | Symbol window length in macroticks |
| cfg_nit_len | input | SEG_W | Network idle length in macroticks |
| cfg_frame_len | input | LEN_W | Length of a dynamic frame in macroticks |
| tx_pending | input | PEND_W | Pending-frame bitmap, bit n is frame ID n |
| bus_busy | input | 1 | Another node is transmitting |
| slot_id | output | ID_W | Current frame ID, 0 outside the slotted phases |
| segment | output | 2 | 0 static, 1 dynamic, 2 symbol window, 3 network idle |
| cycle | output | CYC_W | Communication cycle counter |
| tx_grant | output | 1 | One-clock grant to start the current frame |

## Verification
The first sweep uses three static slots and a fourteen-macrotick dynamic segment over three cycles, with the pending set and the frame length changed between cycles. A frame that fits shows that the slot stretches to the frame length. A frame that arrives late in the segment shows that the fit rule withholds it, and its grant in a later cycle shows that it was held rather than dropped. A single busy minislot in one cycle separates the extension rule from the plain idle minislot. A second sweep with every length set to one runs past 64 cycles to test the counter wrap and the extreme case where a frame exactly fills the segment. A window without macroticks checks that the state holds.

// File: rtl/tt_sched_pkg.sv
package tt_sched_pkg;
  typedef enum logic [1:0] {
    SEG_STATIC = 2'd0,
    SEG_DYN    = 2'd1,
    SEG_SYM    = 2'd2,
    SEG_NIT    = 2'd3
  } seg_e;
endpackage

// File: rtl/tt_grant_eval.sv
module tt_grant_eval #(
  parameter int ID_W   = 11,
  parameter int LEN_W  = 8,
  parameter int SEG_W  = 16,
  parameter int PEND_W = 64
) (
  input  logic [ID_W-1:0]   slot_id,
  input  logic              in_static,
  input  logic              in_dyn,
  input  logic [PEND_W-1:0] pending,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic [SEG_W-1:0]  seg_rem,
  output logic              want
);
  localparam int IDX_W = $clog2(PEND_W);
  localparam logic [ID_W:0] LIMIT = (ID_W+1)'(PEND_W);

  logic in_range;
  logic hit;
  logic fits;

  // IDs past the bitmap are never pending
  assign in_range = {1'b0, slot_id} < LIMIT;
  assign hit      = in_range && pending[slot_id[IDX_W-1:0]];
  // frame must end inside the dynamic segment
  assign fits     = SEG_W'(frame_len) <= seg_rem;
  assign want     = hit && (in_static || (in_dyn && fits));
endmodule

// File: rtl/tt_cycle_ctr.sv
module tt_cycle_ctr #(
  parameter int CYC_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CYC_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (inc) cnt <= cnt + CYC_W'(1);
  end
endmodule

// File: rtl/tt_slot_sched.sv
module tt_slot_sched
  import tt_sched_pkg::*;
#(
  parameter int ID_W   = 11,
  parameter int LEN_W  = 8,
  parameter int SEG_W  = 16,
  parameter int PEND_W = 64,
  parameter int CYC_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mt_en,
  input  logic [ID_W-1:0]   cfg_static_slots,
  input  logic [LEN_W-1:0]  cfg_static_len,
  input  logic [LEN_W-1:0]  cfg_minislot_len,
  input  logic [SEG_W-1:0]  cfg_dyn_len,
  input  logic [SEG_W-1:0]  cfg_sym_len,
  input  logic [SEG_W-1:0]  cfg_nit_len,
  input  logic [LEN_W-1:0]  cfg_frame_len,
  input  logic [PEND_W-1:0] tx_pending,
  input  logic              bus_busy,
  output logic [ID_W-1:0]   slot_id,
  output logic [1:0]        segment,
  output logic [CYC_W-1:0]  cycle,
  output logic              tx_grant
);
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
  localparam logic [SEG_W-1:0] SEG_ONE = SEG_W'(1);
  localparam logic [ID_W-1:0]  ID_ONE  = ID_W'(1);

  seg_e             seg_q, seg_d;
  logic [ID_W-1:0]  slot_q, slot_d;
  logic [LEN_W-1:0] srem_q, srem_d;   // macroticks left in slot, current included
  logic [SEG_W-1:0] grem_q, grem_d;   // macroticks left in segment, current included
  logic             fresh_q, fresh_d; // current macrotick is the slot's first
  logic             own_q, own_d;     // this node is sending in the dynamic slot
  logic             grant_q, grant_d;
  logic             cyc_inc;
  logic             want;
  logic             start_own;

  tt_grant_eval #(
    .ID_W(ID_W), .LEN_W(LEN_W), .SEG_W(SEG_W), .PEND_W(PEND_W)
  ) u_eval (
    .slot_id   (slot_q),
    .in_static (seg_q == SEG_STATIC),
    .in_dyn    (seg_q == SEG_DYN),
    .pending   (tx_pending),
    .frame_len (cfg_frame_len),
    .seg_rem   (grem_q),
    .want      (want)
  );

  tt_cycle_ctr #(.CYC_W(CYC_W)) u_cyc (
    .clk (clk),
    .rst (rst),
    .inc (cyc_inc),
    .cnt (cycle)
  );

  assign start_own = fresh_q && want && (seg_q == SEG_DYN);

  always_comb begin
    seg_d   = seg_q;
    slot_d  = slot_q;
    srem_d  = srem_q;
    grem_d  = grem_q;
    fresh_d = fresh_q;
    own_d   = own_q;
    grant_d = 1'b0;
    cyc_inc = 1'b0;
    if (mt_en) begin
      grant_d = fresh_q && want;
      fresh_d = 1'b0;
      unique case (seg_q)
        SEG_STATIC: begin
          if (srem_q == LEN_ONE) begin
            slot_d  = slot_q + ID_ONE;
            fresh_d = 1'b1;
            if (slot_q == cfg_static_slots) begin
              seg_d  = SEG_DYN;
              grem_d = cfg_dyn_len;
              srem_d = cfg_minislot_len;
              own_d  = 1'b0;
            end else begin
              srem_d = cfg_static_len;
            end
          end else begin
            srem_d = srem_q - LEN_ONE;
          end
        end
        SEG_DYN: begin
          if (grem_q == SEG_ONE) begin
            seg_d  = SEG_SYM;
            slot_d = '0;
            grem_d = cfg_sym_len;
            own_d  = 1'b0;
          end else begin
            grem_d = grem_q - SEG_ONE;
            if (start_own && cfg_frame_len != LEN_ONE) begin
              own_d  = 1'b1;
              srem_d = cfg_frame_len - LEN_ONE;
            end else if (start_own || srem_q == LEN_ONE) begin
              if (!start_own && !own_q && bus_busy) begin
                srem_d = cfg_minislot_len;
              end else begin
                slot_d  = slot_q + ID_ONE;
                srem_d  = cfg_minislot_len;
                fresh_d = 1'b1;
                own_d   = 1'b0;
              end
            end else begin
              srem_d = srem_q - LEN_ONE;
            end
          end
        end
        SEG_SYM: begin
          if (grem_q == SEG_ONE) begin
            seg_d  = SEG_NIT;
            grem_d = cfg_nit_len;
          end else begin
            grem_d = grem_q - SEG_ONE;
          end
        end
        SEG_NIT: begin
          if (grem_q == SEG_ONE) begin
            seg_d   = SEG_STATIC;
            slot_d  = ID_ONE;
            srem_d  = cfg_static_len;
            fresh_d = 1'b1;
            cyc_inc = 1'b1;
          end else begin
            grem_d = grem_q - SEG_ONE;
          end
        end
        default: seg_d = SEG_STATIC;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q   <= SEG_STATIC;
      slot_q  <= ID_ONE;
      srem_q  <= cfg_static_len;
      grem_q  <= '0;
      fresh_q <= 1'b1;
      own_q   <= 1'b0;
      grant_q <= 1'b0;
    end else begin
      seg_q   <= seg_d;
      slot_q  <= slot_d;
      srem_q  <= srem_d;
      grem_q  <= grem_d;
      fresh_q <= fresh_d;
      own_q   <= own_d;
      grant_q <= grant_d;
    end
  end

  assign slot_id  = slot_q;
  assign segment  = seg_q;
  assign tx_grant = grant_q;
endmodule

// File: rtl/tt_slot_sched_chk.sv
module tt_slot_sched_chk #(
  parameter int ID_W  = 11,
  parameter int CYC_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             mt_en,
  input logic [ID_W-1:0]  cfg_static_slots,
  input logic [ID_W-1:0]  slot_id,
  input logic [1:0]       segment,
  input logic [CYC_W-1:0] cycle,
  input logic             tx_grant
);
  assert_grant_on_action_point_R10: assert property (@(posedge clk) disable iff (rst)
    tx_grant |-> $past(mt_en));

  assert_hold_without_tick_R10: assert property (@(posedge clk) disable iff (rst)
    !mt_en |=> ($stable(segment) && $stable(slot_id) && $stable(cycle)));

  assert_grant_one_clock_R3: assert property (@(posedge clk) disable iff (rst)
    tx_grant |=> !tx_grant);

  assert_static_id_range_R2: assert property (@(posedge clk) disable iff (rst)
    (segment == 2'd0) |-> (slot_id != '0 && slot_id <= cfg_static_slots));

  assert_first_dyn_id_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(segment) == 2'd0 && segment == 2'd1) |-> (slot_id == $past(slot_id) + ID_W'(1)));

  assert_segment_order_R8: assert property (@(posedge clk) disable iff (rst)
    (segment != $past(segment)) |-> (segment == $past(segment) + 2'd1));

  assert_cycle_step_R9: assert property (@(posedge clk) disable iff (rst)
    (cycle != $past(cycle)) |->
      (cycle == $past(cycle) + CYC_W'(1) && $past(segment) == 2'd3 && segment == 2'd0));
endmodule

bind tt_slot_sched tt_slot_sched_chk #(.ID_W(ID_W), .CYC_W(CYC_W)) u_chk (
  .clk              (clk),
  .rst              (rst),
  .mt_en            (mt_en),
  .cfg_static_slots (cfg_static_slots),
  .slot_id          (slot_id),
  .segment          (segment),
  .cycle            (cycle),
  .tx_grant         (tx_grant)
);

// File: tb/tt_slot_sched_test.sv
`timescale 1ns/1ps
module tt_slot_sched_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mt_en = 1'b0;
  logic [10:0] cfg_static_slots;
  logic [7:0]  cfg_static_len, cfg_minislot_len, cfg_frame_len;
  logic [15:0] cfg_dyn_len, cfg_sym_len, cfg_nit_len;
  logic [63:0] tx_pending;
  logic        bus_busy = 1'b0;
  logic [10:0] slot_id;
  logic [1:0]  segment;
  logic [5:0]  cycle;
  logic        tx_grant;

  int total = 0, fails = 0;
  bit done = 0;
  // bench expectations
  int e_seg, e_slot, e_cyc, e_srem, e_grem;
  bit e_fresh, e_own, e_ext, e_grant, e_wrap, phase_a;
  string gtag;

  always #2.5 clk = ~clk;

  tt_slot_sched uut (
    .clk(clk), .rst(rst), .mt_en(mt_en),
    .cfg_static_slots(cfg_static_slots), .cfg_static_len(cfg_static_len),
    .cfg_minislot_len(cfg_minislot_len), .cfg_dyn_len(cfg_dyn_len),
    .cfg_sym_len(cfg_sym_len), .cfg_nit_len(cfg_nit_len),
    .cfg_frame_len(cfg_frame_len), .tx_pending(tx_pending), .bus_busy(bus_busy),
    .slot_id(slot_id), .segment(segment), .cycle(cycle), .tx_grant(tx_grant)
  );

  task automatic chk(bit ok, string tag, string act, string exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %s expected %s", tag, act, exp);
    end
  endtask

  task automatic chk_state(string tag);
    chk(segment == e_seg[1:0] && slot_id == e_slot[10:0] && cycle == e_cyc[5:0], tag,
        $sformatf("seg=%0d id=%0d cyc=%0d", segment, slot_id, cycle),
        $sformatf("seg=%0d id=%0d cyc=%0d", e_seg, e_slot, e_cyc));
  endtask

  task automatic model_reset();
    e_seg = 0; e_slot = 1; e_cyc = 0; e_srem = int'(cfg_static_len); e_grem = 0;
    e_fresh = 1; e_own = 0; e_ext = 0; e_grant = 0; e_wrap = 0;
  endtask

  task automatic next_dyn();
    e_slot++; e_srem = int'(cfg_minislot_len); e_fresh = 1; e_own = 0; e_ext = 0;
  endtask

  // one macrotick of the expected timeline
  task automatic model_step();
    bit hit, fit, own_start;
    hit = (e_slot < 64) && tx_pending[e_slot];
    fit = int'(cfg_frame_len) <= e_grem;
    e_grant = 0; own_start = 0;
    gtag = (e_seg == 0) ? "R3" : (e_seg == 1) ? "R4" : "R8";
    if (e_fresh && e_seg == 0 && hit) e_grant = 1;
    if (e_fresh && e_seg == 1 && hit) begin
      if (fit) begin e_grant = 1; own_start = 1; gtag = "R6"; end
      else gtag = "R7";
    end
    e_fresh = 0;
    case (e_seg)
      0: if (e_srem == 1) begin
           if (e_slot == int'(cfg_static_slots)) begin
             e_seg = 1; e_grem = int'(cfg_dyn_len); next_dyn();
           end else begin
             e_slot++; e_srem = int'(cfg_static_len); e_fresh = 1;
           end
         end else e_srem--;
      1: if (e_grem == 1) begin
           e_seg = 2; e_slot = 0; e_grem = int'(cfg_sym_len); e_own = 0;
         end else begin
           e_grem--;
           if (own_start) begin
             if (cfg_frame_len == 1) next_dyn();
             else begin e_own = 1; e_srem = int'(cfg_frame_len) - 1; end
           end else if (e_srem == 1) begin
             if (!e_own && bus_busy) begin e_srem = int'(cfg_minislot_len); e_ext = 1; end
             else next_dyn();
           end else e_srem--;
         end
      2: if (e_grem == 1) begin e_seg = 3; e_grem = int'(cfg_nit_len); end
         else e_grem--;
      default: if (e_grem == 1) begin
           e_seg = 0; e_slot = 1; e_srem = int'(cfg_static_len); e_fresh = 1;
           e_wrap = (e_cyc == 63); e_cyc = (e_cyc + 1) % 64;
         end else e_grem--;
    endcase
  endtask

  task automatic tick();
    string stag;
    @(negedge clk);
    bus_busy = phase_a && e_cyc == 1 && e_seg == 1 && e_slot == 4 && !e_ext;
    if (e_wrap) stag = "R9";
    else if (e_seg == 0) stag = "R2";
    else if (e_seg == 1) stag = e_ext ? "R5" : "R4";
    else stag = "R8";
    e_wrap = 0;
    chk_state(stag);
    model_step();
    mt_en = 1'b1;
    @(negedge clk);
    mt_en = 1'b0;
    chk(tx_grant == e_grant, gtag, $sformatf("grant=%0b", tx_grant),
        $sformatf("grant=%0b", e_grant));
  endtask

  task automatic do_reset();
    rst = 1'b1; mt_en = 1'b0; bus_busy = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
    @(negedge clk);
    chk(segment == 2'd0 && slot_id == 11'd1 && cycle == 6'd0 && !tx_grant, "R1",
        $sformatf("seg=%0d id=%0d cyc=%0d g=%0b", segment, slot_id, cycle, tx_grant),
        "seg=0 id=1 cyc=0 g=0");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    #(150000 * 5);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    bit changed;
    // sweep A: three cycles, fit rule and busy extension
    phase_a = 1;
    cfg_static_slots = 11'd3; cfg_static_len = 8'd4; cfg_minislot_len = 8'd2;
    cfg_dyn_len = 16'd14; cfg_sym_len = 16'd2; cfg_nit_len = 16'd3;
    cfg_frame_len = 8'd5;
    tx_pending = '0;
    tx_pending[2] = 1'b1; tx_pending[5] = 1'b1; tx_pending[8] = 1'b1;
    do_reset();
    changed = 0;
    while (e_cyc < 3) begin
      if (e_cyc == 2 && !changed) begin
        @(negedge clk);
        changed = 1;
        tx_pending = '0;
        tx_pending[1] = 1'b1; tx_pending[3] = 1'b1; tx_pending[8] = 1'b1;
        cfg_frame_len = 8'd3;
      end
      tick();
    end
    // no macroticks: everything holds (R10)
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(segment == e_seg[1:0] && slot_id == e_slot[10:0] && cycle == e_cyc[5:0] && !tx_grant,
          "R10", $sformatf("seg=%0d id=%0d g=%0b", segment, slot_id, tx_grant),
          $sformatf("seg=%0d id=%0d g=0", e_seg, e_slot));
    end
    // sweep B: all lengths one, run past the cycle wrap (R9)
    phase_a = 0;
    cfg_static_slots = 11'd1; cfg_static_len = 8'd1; cfg_minislot_len = 8'd1;
    cfg_dyn_len = 16'd1; cfg_sym_len = 16'd1; cfg_nit_len = 16'd1;
    cfg_frame_len = 8'd1;
    tx_pending = '0; tx_pending[1] = 1'b1; tx_pending[2] = 1'b1;
    do_reset();
    for (int m = 0; m < 4 * 66; m++) tick();
    chk(cycle == 6'd2, "R9", $sformatf("cyc=%0d", cycle), "cyc=2");
    finish_run();
  end
endmodule